// File: doc/BRIEF.md
# Warm-reboot command word sequencer

This block feeds the 16-bit write-only command input of an FPGA's internal configuration port so that the device restarts from a chosen image. A one-cycle start request captures three operands: a 24-bit primary image address, a 24-bit backup image address and an 8-bit opcode. The block then plays out a fixed 14-word stream. The stream opens with a dummy word and the sync pair. It loads four general configuration registers with the two addresses and the opcode. It ends by writing the reprogram command and a trailing no-op.

Each word goes out over a valid/stall handshake, with the port enable and write strobe held active while the stream runs. A parameter can reverse the bit order inside every byte on the way out, as some configuration ports require. A one-cycle done pulse marks acceptance of the final word. If the sink stalls for too long, a watchdog abandons the stream and raises a sticky error.

Top module: `reboot_seq`

## Requirements
- R1: While rst_ni is low and right after it is released, valid_o, en_o, wr_o, busy_o, done_o and err_o are 0 and word_o is 16'h0000.
- R2: A start_i seen while idle captures the operands; the first three words are 16'hFFFF, 16'hAA99, 16'h5566 (index 0..2).
- R3: Words at index 4 and 6 are the primary address bits [15:0], then {opcode, primary address bits [23:16]}.
- R4: Words at index 8 and 10 are the backup address bits [15:0], then {opcode, backup address bits [23:16]}.
- R5: Words at index 11..13 are 16'h30A1, the reprogram value 16'h000E and the no-op 16'h2000, the last word of the stream.
- R6: Headers at index 3, 5, 7, 9, 11 have 3'b001 in [15:13], 2'b10 (write) in [12:11], the register number in [10:5] (6'h13, 6'h14, 6'h15, 6'h16 for the four general registers, 6'h05 for the command register) and word count 1 in [4:0].
- R7: With BIT_REV=1 (default), output bit 8*b+j carries bit 8*b+7-j of the word listed above, for each byte b.
- R8: A word advances only on a clock edge where valid_o is 1 and stall_i is 0; while stalled, word_o and valid_o hold.
- R9: en_o and wr_o are 1 exactly while valid_o is 1, and word_o is 0 while valid_o is 0.
- R10: busy_o is 1 from the first word until done_o; done_o is a single-cycle pulse in the cycle after the last word is accepted.
- R11: start_i asserted while busy_o is 1 is ignored: the stream continues with the originally captured operands.
- R12: If stall_i is 1 for WDOG_LIMIT (default 4096) consecutive cycles while valid_o is 1, the block returns to idle without a done pulse and sets err_o.
- R13: err_o stays set until the next accepted start_i, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| mb_addr_i | input | 24 | Primary image start address |
| fb_addr_i | input | 24 | Backup image start address |
| opcode_i | input | 8 | Opcode placed in the upper byte of the address-high words |
| stall_i | input | 1 | Sink cannot accept the current word |
| word_o | output | 16 | Command word to the configuration port |
| valid_o | output | 1 | word_o is valid |
| en_o | output | 1 | Port enable |
| wr_o | output | 1 | Port write strobe |
| busy_o | output | 1 | Stream in progress |
| done_o | output | 1 | Final word accepted (one cycle) |
| err_o | output | 1 | Sticky watchdog abort flag |

## Verification
The hardest state to reach from the ports is the watchdog abort. The sink must hold stall for a full 4096 consecutive cycles without a single accept, and must do so mid-stream rather than only on the first word. The bench gets there with a directed run that lets a few words through and then holds stall_i high. It counts the cycles until valid_o drops, then confirms that no done pulse occurred and that the next start clears the error. Random stall patterns at several densities cover the hold behaviour on every word position. A start pulse injected mid-stream with different operands shows that the captured values do not change.

// File: rtl/reboot_pkg.sv
package reboot_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 24;
  localparam int OP_W    = 8;
  localparam int SEQ_LEN = 14;
  localparam int IDX_W   = $clog2(SEQ_LEN);

  localparam logic [WORD_W-1:0] W_DUMMY  = 16'hFFFF;
  localparam logic [WORD_W-1:0] W_SYNC_A = 16'hAA99;
  localparam logic [WORD_W-1:0] W_SYNC_B = 16'h5566;
  localparam logic [WORD_W-1:0] W_REPROG = 16'h000E;
  localparam logic [WORD_W-1:0] W_NOOP   = 16'h2000;

  localparam logic [5:0] RA_GEN1 = 6'h13;
  localparam logic [5:0] RA_GEN2 = 6'h14;
  localparam logic [5:0] RA_GEN3 = 6'h15;
  localparam logic [5:0] RA_GEN4 = 6'h16;
  localparam logic [5:0] RA_CMD  = 6'h05;

  typedef enum logic { ST_IDLE, ST_RUN } seq_state_t;

  // type-1 write header, one word
  function automatic logic [WORD_W-1:0] hdr_wr1(input logic [5:0] ra);
    return {3'b001, 2'b10, ra, 5'd1};
  endfunction
endpackage

// File: rtl/reboot_word_sel.sv
module reboot_word_sel
  import reboot_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] mb_i,
  input  logic [ADDR_W-1:0] fb_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    unique case (idx_i)
      IDX_W'(0):  word_o = W_DUMMY;
      IDX_W'(1):  word_o = W_SYNC_A;
      IDX_W'(2):  word_o = W_SYNC_B;
      IDX_W'(3):  word_o = hdr_wr1(RA_GEN1);
      IDX_W'(4):  word_o = mb_i[15:0];
      IDX_W'(5):  word_o = hdr_wr1(RA_GEN2);
      IDX_W'(6):  word_o = {op_i, mb_i[23:16]};
      IDX_W'(7):  word_o = hdr_wr1(RA_GEN3);
      IDX_W'(8):  word_o = fb_i[15:0];
      IDX_W'(9):  word_o = hdr_wr1(RA_GEN4);
      IDX_W'(10): word_o = {op_i, fb_i[23:16]};
      IDX_W'(11): word_o = hdr_wr1(RA_CMD);
      IDX_W'(12): word_o = W_REPROG;
      default:    word_o = W_NOOP;
    endcase
  end
endmodule

// File: rtl/reboot_bitrev.sv
module reboot_bitrev #(
  parameter int W  = 16,
  parameter bit EN = 1'b1
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int NBYTES = W / 8;
  if (EN) begin : g_rev
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      for (genvar j = 0; j < 8; j++) begin : g_bit
        assign q_o[8*b+j] = d_i[8*b+7-j];
      end
    end
  end else begin : g_pass
    assign q_o = d_i;
  end
endmodule

// File: rtl/reboot_wdog.sv
module reboot_wdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stalled_i,
  output logic trip_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign trip_o = stalled_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!stalled_i || trip_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_WDOG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LIMIT)); // R12
endmodule

// File: rtl/reboot_seq.sv
module reboot_seq
  import reboot_pkg::*;
#(
  parameter bit BIT_REV    = 1'b1,
  parameter int WDOG_LIMIT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [23:0]       mb_addr_i,
  input  logic [23:0]       fb_addr_i,
  input  logic [7:0]        opcode_i,
  input  logic              stall_i,
  output logic [15:0]       word_o,
  output logic              valid_o,
  output logic              en_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] mb_q, fb_q;
  logic [OP_W-1:0]   op_q;
  logic              done_q, err_q;
  logic              run, trip;
  logic [WORD_W-1:0] raw_word, out_word;

  assign run = (state_q == ST_RUN);

  reboot_word_sel u_sel (
    .idx_i (idx_q),
    .mb_i  (mb_q),
    .fb_i  (fb_q),
    .op_i  (op_q),
    .word_o(raw_word)
  );

  reboot_bitrev #(.W(WORD_W), .EN(BIT_REV)) u_rev (
    .d_i(raw_word),
    .q_o(out_word)
  );

  reboot_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stalled_i(run && stall_i),
    .trip_o   (trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mb_q    <= '0;
      fb_q    <= '0;
      op_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mb_q    <= mb_addr_i;
            fb_q    <= fb_addr_i;
            op_q    <= opcode_i;
            idx_q   <= '0;
            err_q   <= 1'b0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (trip) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!stall_i) begin
            if (idx_q == LAST_IDX) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = run;
  assign en_o    = run;
  assign wr_o    = run;
  assign busy_o  = run;
  assign word_o  = run ? out_word : '0;
  assign done_o  = done_q;
  assign err_o   = err_q;

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i && !trip) |=> (valid_o && $stable(word_o))); // R8
  AST_FIRST_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (word_o == 16'hFFFF)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o && !stall_i)); // R10
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!done_o && !valid_o)); // R12
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && stall_i && !trip) |=> $stable(word_o)); // R11
endmodule

// File: tb/sim_reboot_seq.sv
module sim_reboot_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] mb_addr_i = '0;
  logic [23:0] fb_addr_i = '0;
  logic [7:0]  opcode_i = '0;
  logic        stall_i = 1'b0;
  logic [15:0] word_o;
  logic        valid_o, en_o, wr_o, busy_o, done_o, err_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  reboot_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mb_addr_i(mb_addr_i), .fb_addr_i(fb_addr_i), .opcode_i(opcode_i),
    .stall_i(stall_i), .word_o(word_o), .valid_o(valid_o), .en_o(en_o),
    .wr_o(wr_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] brev(input logic [15:0] w);
    logic [15:0] r;
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < 8; j++) r[8*b+j] = w[8*b+7-j];
    return r;
  endfunction

  function automatic logic [15:0] hdr(input logic [5:0] ra);
    return {3'b001, 2'b10, ra, 5'd1};
  endfunction

  function automatic logic [15:0] exp_word(input int i, input logic [23:0] mb,
                                           input logic [23:0] fb, input logic [7:0] op);
    case (i)
      0: return 16'hFFFF;
      1: return 16'hAA99;
      2: return 16'h5566;
      3: return hdr(6'h13);
      4: return mb[15:0];
      5: return hdr(6'h14);
      6: return {op, mb[23:16]};
      7: return hdr(6'h15);
      8: return fb[15:0];
      9: return hdr(6'h16);
      10: return {op, fb[23:16]};
      11: return hdr(6'h05);
      12: return 16'h000E;
      default: return 16'h2000;
    endcase
  endfunction

  function automatic string tag(input int i);
    if (i < 3) return "R2 R7";
    if (i == 3 || i == 5 || i == 7 || i == 9 || i == 11) return "R6 R7";
    if (i == 4 || i == 6) return "R3 R7";
    if (i == 8 || i == 10) return "R4 R7";
    return "R5 R7";
  endfunction

  task automatic run_seq(input logic [23:0] mb, input logic [23:0] fb,
                         input logic [7:0] op, input int stall_pct, input bit poke);
    int idx = 0;
    int cyc = 0;
    @(negedge clk_i);
    start_i = 1; mb_addr_i = mb; fb_addr_i = fb; opcode_i = op; stall_i = 0;
    @(negedge clk_i);
    start_i = 0;
    mb_addr_i = $urandom; fb_addr_i = $urandom; opcode_i = $urandom;
    chk("R10 busy at first word", busy_o, 1);
    chk("R13 err cleared by start", err_o, 0);
    while (idx < 14 && cyc < 2000) begin
      chk("R8 valid held", valid_o, 1);
      chk(tag(idx), word_o, brev(exp_word(idx, mb, fb, op)));
      chk("R9 en/wr", {en_o, wr_o}, 2'b11);
      chk("R10 no early done", done_o, 0);
      start_i = (poke && idx == 5);  // R11 mid-stream start
      stall_i = ($urandom_range(99) < stall_pct);
      if (!stall_i) idx++;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 0; stall_i = 0;
    chk("R10 done pulse", done_o, 1);
    chk("R10 busy low at done", busy_o, 0);
    chk("R9 idle outputs", {valid_o, en_o, wr_o, word_o}, 0);
    @(negedge clk_i);
    chk("R10 done single cycle", done_o, 0);
    chk("R11 no restart after poke", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    #1;
    chk("R1 in reset", {valid_o, en_o, wr_o, busy_o, done_o, err_o, word_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after reset", {valid_o, en_o, wr_o, busy_o, done_o, err_o, word_o}, 0);

    // directed: asymmetric bytes expose reversal
    run_seq(24'h80_0001, 24'h01_0080, 8'h0B, 0, 0);
    run_seq(24'hFEDCBA, 24'h123456, 8'hA5, 40, 1);
    for (int r = 0; r < 8; r++)
      run_seq($urandom, $urandom, $urandom, (r * 13) % 90, r[0]);

    // watchdog: let three words through, then stall forever
    begin
      int n = 0;
      bit saw_done = 0;
      @(negedge clk_i);
      start_i = 1; mb_addr_i = 24'h111111; fb_addr_i = 24'h222222; opcode_i = 8'h33;
      @(negedge clk_i);
      start_i = 0;
      repeat (3) @(negedge clk_i);
      stall_i = 1;
      while (valid_o && n < 5000) begin
        if (done_o) saw_done = 1;
        n++;
        @(negedge clk_i);
      end
      chk("R12 abort after limit cycles", n, 4096);
      chk("R12 no done on abort", {saw_done, done_o}, 0);
      chk("R12 err set, idle", {err_o, busy_o, valid_o}, 3'b100);
      stall_i = 0;
      repeat (5) @(negedge clk_i);
      chk("R13 err sticky", err_o, 1);
      run_seq(24'hABCDEF, 24'h654321, 8'h5A, 20, 0);
      chk("R13 err stays clear", err_o, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule